// File: doc/BRIEF.md
# Two-Phase Multiplexed ADC Model with SPI Slave Port

This block stands in for a multiplexed converter when a sequencer is being checked. It has an SPI slave port and a bank of per-channel digital words that play the part of the analog inputs. The converter alternates between two phases. While chip select is low it acquires on the channel the mux selects. A rising chip select freezes that sample and starts a conversion. When the conversion ends, the converter goes back to acquiring.

Each frame carries a configuration word, and the frame also shifts out the result of the previous conversion. A configuration only steers acquisitions that begin after the frame carrying it has closed. So the word returned in a frame belongs to the configuration sent two frames earlier. A sequencer that forgets this lag reads data from the wrong channel, and this model shows that error at its pins.

All SPI inputs are sampled by the system clock and edge-detected. The SPI clock must therefore run well below the system clock. The conversion time is a parameter. A frame that starts too early is answered with stale data and raises an error flag.

Top module: `mux_adc_model`

## Requirements
- R1: After reset `miso` and `proto_err` are 0, and the first two complete frames return an all-zero data word.
- R2: A frame shifts out RES data bits, most significant first. The first bit is on `miso` after chip select falls and before the first rising `sclk`. Each later bit appears after a falling `sclk`.
- R3: The first 14 bits received on `mosi` in a frame form the configuration word, most significant bit first. The channel number is the low log2(NUM_CH) bits of configuration bits 9:7, and no other configuration bit affects the selection.
- R4: A configuration written in frame N steers the sample that frame N+2 returns. Frame N+1 still returns the channel selected before frame N.
- R5: The sample is the selected channel's input word at the rising chip-select edge. Input changes after that edge do not alter it.
- R6: While the configuration stays the same, every frame returns the selected channel's word.
- R7: A frame that ends with fewer than 14 rising `sclk` edges leaves the configuration unchanged.
- R8: A conversion lasts CONV_CYCLES clock cycles. A frame that starts before the conversion finishes returns the previous frame's data, and `proto_err` is 1 for that frame. The next frame that starts on time clears `proto_err`.
- R9: The conversion result changes only when a conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI clock, mode 0 |
| mosi | input | 1 | Serial configuration in |
| chan_in | input | NUM_CH*RES | Input words, channel k at bits [k*RES +: RES] |
| miso | output | 1 | Serial data out |
| proto_err | output | 1 | Current frame started during a conversion |

## Verification
Suppose the active configuration is taken one frame too early, or the mux is steered by the incoming word. The channel changes at the first frame after a switch, one frame ahead of the two-frame lag, and the word comparison catches it. A wrong channel-field offset, or a short frame that latches its word, shows up as the wrong channel's word within two frames. A missing busy check, or a conversion counter that is too short, shows up in the very frame that starts early, either as a missing error flag or as fresh data where stale data is due.

// File: rtl/adcm_pkg.sv
package adcm_pkg;
  localparam int CFG_W   = 14;  // configuration bits at the head of a frame
  localparam int SEL_LSB = 7;   // lowest bit of the channel field in that word
endpackage

// File: rtl/adcm_sync.sv
module adcm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic mosi_i,
  output logic cs_fall,
  output logic cs_rise,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_low,
  output logic mosi_s
);
  logic [STAGES-1:0] cs_q, sclk_q, mosi_q;
  logic cs_p, sclk_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= '1;
      sclk_q <= '0;
      mosi_q <= '0;
      cs_p   <= 1'b1;
      sclk_p <= 1'b0;
    end else begin
      cs_q   <= {cs_q[STAGES-2:0], cs_n_i};
      sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
      mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
      cs_p   <= cs_q[STAGES-1];
      sclk_p <= sclk_q[STAGES-1];
    end
  end

  assign cs_low    = ~cs_q[STAGES-1];
  assign cs_fall   = cs_p & ~cs_q[STAGES-1];
  assign cs_rise   = ~cs_p & cs_q[STAGES-1];
  assign sclk_rise = cs_low & ~sclk_p & sclk_q[STAGES-1];
  assign sclk_fall = cs_low & sclk_p & ~sclk_q[STAGES-1];
  assign mosi_s    = mosi_q[STAGES-1];
endmodule

// File: rtl/adcm_cfg.sv
module adcm_cfg
  import adcm_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sclk_rise,
  input  logic             mosi_s,
  output logic [SEL_W-1:0] act_ch,
  output logic             act_valid
);
  localparam int SH_W  = SEL_LSB + SEL_W;
  localparam int CNT_W = $clog2(CFG_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CFG_W);

  logic [SH_W-1:0]  sh;
  logic [CNT_W-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      bits      <= '0;
      act_ch    <= '0;
      act_valid <= 1'b0;
    end else begin
      if (cs_fall) begin
        bits <= '0;
      end else if (sclk_rise && bits != FULL) begin
        sh   <= {sh[SH_W-2:0], mosi_s};
        bits <= bits + 1'b1;
      end
      if (cs_rise && bits == FULL) begin
        act_ch    <= sh[SEL_LSB +: SEL_W];
        act_valid <= 1'b1;
      end
    end
  end

  p_cfg_at_frame_end_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_ch) |-> $past(cs_rise));
  p_valid_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    $past(act_valid) |-> act_valid);
endmodule

// File: rtl/adcm_conv.sv
module adcm_conv #(
  parameter int RES         = 16,
  parameter int NUM_CH      = 8,
  parameter int SEL_W       = 3,
  parameter int CONV_CYCLES = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_rise,
  input  logic [SEL_W-1:0]      act_ch,
  input  logic                  act_valid,
  input  logic [NUM_CH*RES-1:0] chan_in,
  output logic [RES-1:0]        result,
  output logic                  busy
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CONV_CYCLES);

  logic [RES-1:0] hold;
  logic [CW-1:0]  left;

  assign busy = (left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold   <= '0;
      left   <= '0;
      result <= '0;
    end else if (cs_rise) begin
      hold <= act_valid ? chan_in[act_ch*RES +: RES] : '0;
      left <= LOAD;
    end else if (busy) begin
      left <= left - 1'b1;
      if (left == CW'(1)) result <= hold;
    end
  end

  p_result_on_done_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> ($past(busy) && !busy));
endmodule

// File: rtl/mux_adc_model.sv
module mux_adc_model #(
  parameter int RES         = 16,
  parameter int NUM_CH      = 8,
  parameter int CONV_CYCLES = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_n,
  input  logic                  sclk,
  input  logic                  mosi,
  input  logic [NUM_CH*RES-1:0] chan_in,
  output logic                  miso,
  output logic                  proto_err
);
  localparam int SEL_W = $clog2(NUM_CH);

  logic cs_fall, cs_rise, sclk_rise, sclk_fall, cs_low, mosi_s;
  logic [SEL_W-1:0] act_ch;
  logic             act_valid, busy;
  logic [RES-1:0]   result, tx;

  adcm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .mosi_i(mosi),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .cs_low(cs_low), .mosi_s(mosi_s)
  );

  adcm_cfg #(.SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .mosi_s(mosi_s),
    .act_ch(act_ch), .act_valid(act_valid)
  );

  adcm_conv #(.RES(RES), .NUM_CH(NUM_CH), .SEL_W(SEL_W),
              .CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk(clk), .rst(rst), .cs_rise(cs_rise), .act_ch(act_ch),
    .act_valid(act_valid), .chan_in(chan_in), .result(result), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx        <= '0;
      proto_err <= 1'b0;
    end else if (cs_fall) begin
      tx        <= result;
      proto_err <= busy;
    end else if (cs_rise) begin
      tx <= '0;
    end else if (sclk_fall && cs_low) begin
      tx <= {tx[RES-2:0], 1'b0};
    end
  end

  assign miso = tx[RES-1];

  p_err_at_start_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(proto_err) |-> $past(cs_fall));
  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    $past(cs_rise) |-> !miso);
endmodule

// File: tb/test_mux_adc_model.sv
module test_mux_adc_model;
  localparam int RES = 16, NUM_CH = 8, CONV = 20, HB = 8, GAP = 40;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, proto_err;
  logic [RES-1:0] cv [NUM_CH];
  logic [NUM_CH*RES-1:0] chan_in;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  always_comb
    for (int k = 0; k < NUM_CH; k++) chan_in[k*RES +: RES] = cv[k];

  mux_adc_model #(.RES(RES), .NUM_CH(NUM_CH), .CONV_CYCLES(CONV)) i_mux_adc_model (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .chan_in(chan_in), .miso(miso), .proto_err(proto_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] mk(input int ch, input logic [13:0] noise);
    return (noise & ~14'(7 << 7)) | 14'((ch & 7) << 7);
  endfunction

  task automatic xfer(input logic [13:0] cfg, input int nbits, input int gap,
                      output logic [RES-1:0] got, output logic err);
    got = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HB) @(negedge clk);
    err = proto_err;
    for (int i = 0; i < nbits; i++) begin
      got[RES-1-i] = miso;
      mosi = (i < 14) ? cfg[13-i] : 1'b0;
      repeat (HB) @(negedge clk);
      sclk = 1'b1;
      repeat (HB) @(negedge clk);
      sclk = 1'b0;
      repeat (HB) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 miso after reset", miso, 0);
    chk("R1 proto_err after reset", proto_err, 0);
  endtask

  task automatic t_lag();
    logic [RES-1:0] g; logic e;
    xfer(mk(3, 0), RES, GAP, g, e); chk("R1 frame1 zero", g, 0);
    xfer(mk(3, 0), RES, GAP, g, e); chk("R1 frame2 zero", g, 0);
    xfer(mk(5, 0), RES, GAP, g, e); chk("R2 first data MSB-first", g, cv[3]);
    xfer(mk(5, 0), RES, GAP, g, e); chk("R4 old channel one frame after switch", g, cv[3]);
    xfer(mk(5, 0), RES, GAP, g, e); chk("R4 new channel two frames after switch", g, cv[5]);
    xfer(mk(5, 0), RES, GAP, g, e); chk("R6 steady channel", g, cv[5]);
  endtask

  task automatic t_sample_edge();
    logic [RES-1:0] g, keep; logic e;
    keep = cv[5];
    xfer(mk(5, 0), RES, GAP, g, e);
    cv[5] = 16'hBEEF;
    xfer(mk(5, 0), RES, GAP, g, e); chk("R5 sample held at cs rise", g, keep);
    xfer(mk(5, 0), RES, GAP, g, e); chk("R5 later sample sees new input", g, 16'hBEEF);
  endtask

  task automatic t_field();
    logic [RES-1:0] g; logic e;
    xfer(mk(2, 14'h3C7F), RES, GAP, g, e);
    xfer(mk(2, 14'h3C7F), RES, GAP, g, e);
    xfer(mk(2, 14'h3C7F), RES, GAP, g, e); chk("R3 channel field 9:7 with noise", g, cv[2]);
    xfer(mk(6, 14'h0000), RES, GAP, g, e);
    xfer(mk(6, 14'h3FFF), RES, GAP, g, e);
    xfer(mk(6, 14'h1555), RES, GAP, g, e); chk("R3 channel 6 field", g, cv[6]);
  endtask

  task automatic t_short();
    logic [RES-1:0] g; logic e;
    xfer(mk(2, 0), RES, GAP, g, e);
    xfer(mk(2, 0), RES, GAP, g, e);
    xfer(mk(6, 0), 10, GAP, g, e); chk("R2 short frame top bits", g >> 6, cv[2] >> 6);
    xfer(mk(2, 0), RES, GAP, g, e); chk("R7 after short frame", g, cv[2]);
    xfer(mk(2, 0), RES, GAP, g, e); chk("R7 config untouched by short frame", g, cv[2]);
  endtask

  task automatic t_early();
    logic [RES-1:0] g; logic e;
    xfer(mk(1, 0), RES, GAP, g, e);
    xfer(mk(1, 0), RES, GAP, g, e);
    xfer(mk(4, 0), RES, 3, g, e);   chk("R8 on-time frame before early one", g, cv[1]);
    chk("R8 no error on time", e, 0);
    xfer(mk(4, 0), RES, GAP, g, e); chk("R8 early frame repeats previous data", g, cv[1]);
    chk("R8 error flag in early frame", e, 1);
    xfer(mk(4, 0), RES, GAP, g, e); chk("R8 R9 data after recovery", g, cv[4]);
    chk("R8 error cleared", e, 0);
  endtask

  initial begin
    for (int k = 0; k < NUM_CH; k++) cv[k] = RES'(16'h1357 * (k + 1) + k);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_lag();
    t_sample_edge();
    t_field();
    t_short();
    t_early();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule